// File: doc/BRIEF.md
# Byte-Serial Pixel Assembler

This block builds 18-bit display pixels from a narrow host bus that delivers each pixel as a series of byte writes. A mode register, written with a one-cycle strobe, selects between three-transfer operation and single-transfer operation. It also holds a 2-bit colour format code. In three-transfer mode, every accepted byte supplies one colour component. The third byte closes the pixel, and the assembled word then leaves on an output stream.

Two colour formats are supported. In the 18-bit format each byte carries a 6-bit component in its upper six bits. In the 16-bit format the three bytes carry 5, 6 and 5 bits, left-aligned in the byte. Each 5-bit component is widened to 6 bits by repeating its top bit in the new bottom bit. In single-transfer mode each accepted write already holds a full 18-bit word, and that word is forwarded unchanged.

Both data sides use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The output holds its word and its valid until the consumer takes it. While an unaccepted pixel waits, the input deasserts ready, so back-pressure propagates upstream without loss. The input also deasserts ready in any cycle where the mode register is written.

Top module: `pix_assembler`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the transfer phase is 0, so the next accepted byte is treated as the first component.
- R2: With three-transfer mode on, the first and second accepted bytes of a pixel produce no output. The third accepted byte makes `out_valid` high in the following cycle.
- R3: Format code 2'b10 takes each component from byte bits [7:2] and ignores bits [1:0]. The pixel is {first[5:0], second[5:0], third[5:0]}, with the first component in bits [17:12].
- R4: Format code 2'b11 takes the first and third components from byte bits [7:3] and the second from bits [7:2]. Each 5-bit value p becomes {p[4:0], p[4]}. The pixel order is the same as in R3, and the unused low bits are ignored.
- R5: Format codes 2'b00 and 2'b01 produce exactly the same pixel as format 2'b10.
- R6: With three-transfer mode off, each accepted write presents `in_data[17:0]` unchanged on `out_pixel`, with `out_valid` high in the next cycle.
- R7: A cycle with `mode_wr` high has `in_ready` low. The new mode applies from the next cycle. A partially received pixel is discarded, and the phase returns to 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_pixel` stays unchanged and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | One-cycle strobe that writes the mode register |
| mode_tri | input | 1 | Three-transfer enable, captured on `mode_wr` |
| mode_fmt | input | 2 | Colour format code, captured on `mode_wr` |
| in_valid | input | 1 | Host write present |
| in_ready | output | 1 | Block can take a host write this cycle |
| in_data | input | 18 | Host write data; only bits [7:0] are used in three-transfer mode |
| out_valid | output | 1 | Assembled pixel present |
| out_ready | input | 1 | Consumer takes the pixel this cycle |
| out_pixel | output | 18 | Assembled pixel {first, second, third} |

## Verification
The embedded properties take for granted that the host holds `in_valid` and `in_data` stable only as a plain source. They check behaviour on accepted transfers alone, and they assume no relationship between `in_valid` and `in_ready`. The stimulus always starts from a mode write, so the phase is known when each pixel starts. It only raises `out_ready` low deliberately, during the back-pressure test, where it also offers a byte that must be refused. Mode writes are never driven together with a data write the test expects to be taken, because R7 makes that byte unacceptable.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
  // Colour format codes held in the mode register
  localparam logic [1:0] FMT_18B = 2'b10;
  localparam logic [1:0] FMT_16B = 2'b11;

  // Widen a short component by one bit, repeating its most significant bit
  function automatic logic [5:0] widen5(input logic [4:0] s);
    return {s, s[4]};
  endfunction
endpackage

// File: rtl/pxa_mode_reg.sv
module pxa_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       tri_in,
  input  logic [1:0] fmt_in,
  output logic       tri_q,
  output logic       is16_q
);
  import pxa_pkg::*;

  logic [1:0] fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q <= 1'b0;
      fmt_q <= FMT_18B;
    end else if (wr) begin
      tri_q <= tri_in;
      fmt_q <= fmt_in;
    end
  end

  // reserved codes fall back to the 18-bit slicing
  assign is16_q = (fmt_q == FMT_16B);
endmodule

// File: rtl/pxa_phase_ctr.sv
module pxa_phase_ctr #(
  parameter int NUM_XFER = 3,
  localparam int PH_W = (NUM_XFER > 1) ? $clog2(NUM_XFER) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_XFER - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (clr)
      phase <= '0;
    else if (step)
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
  end

  assign last = (phase == LAST_PH);

  // R7
  mode_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0));
endmodule

// File: rtl/pxa_slicer.sv
module pxa_slicer #(
  parameter int BYTE_W = 8,
  parameter int COMP_W = 6
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              short_sel,
  output logic [COMP_W-1:0] comp
);
  localparam int SHORT_W = COMP_W - 1;

  logic [COMP_W-1:0]  full_part;
  logic [SHORT_W-1:0] short_part;

  always_comb begin
    full_part  = byte_in[BYTE_W-1 -: COMP_W];
    short_part = byte_in[BYTE_W-1 -: SHORT_W];
    comp = short_sel ? {short_part, short_part[SHORT_W-1]} : full_part;
  end
endmodule

// File: rtl/pxa_out_stage.sv
module pxa_out_stage #(
  parameter int PIX_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] load_data,
  input  logic             take,
  output logic             valid,
  output logic [PIX_W-1:0] pixel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      pixel <= '0;
    end else if (load) begin
      valid <= 1'b1;
      pixel <= load_data;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(pixel)));
endmodule

// File: rtl/pix_assembler.sv
module pix_assembler #(
  parameter int BYTE_W   = 8,
  parameter int COMP_W   = 6,
  parameter int NUM_XFER = 3,
  localparam int PIX_W   = COMP_W * NUM_XFER,
  localparam int PH_W    = (NUM_XFER > 1) ? $clog2(NUM_XFER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic             mode_tri,
  input  logic [1:0]       mode_fmt,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel
);
  logic            tri_q, is16_q;
  logic [PH_W-1:0] phase;
  logic            last_ph;
  logic            in_fire, short_sel, load;
  logic [COMP_W-1:0] comp;
  logic [PIX_W-1:0]  pix_tri, load_data;
  logic [COMP_W-1:0] part_q [NUM_XFER-1];

  pxa_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr),
    .tri_in(mode_tri), .fmt_in(mode_fmt),
    .tri_q(tri_q), .is16_q(is16_q)
  );

  assign in_ready = !mode_wr && (!out_valid || out_ready);
  assign in_fire  = in_valid && in_ready;

  pxa_phase_ctr #(.NUM_XFER(NUM_XFER)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr),
    .step(in_fire && tri_q), .phase(phase), .last(last_ph)
  );

  // short (5-bit) slots are the outer components in 16-bit colour mode
  assign short_sel = is16_q && ((phase == '0) || last_ph);

  pxa_slicer #(.BYTE_W(BYTE_W), .COMP_W(COMP_W)) u_slice (
    .byte_in(in_data[BYTE_W-1:0]), .short_sel(short_sel), .comp(comp)
  );

  // holding registers for all but the closing component
  generate
    for (genvar i = 0; i < NUM_XFER - 1; i++) begin : g_part
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          part_q[i] <= '0;
        else if (in_fire && tri_q && (phase == PH_W'(i)))
          part_q[i] <= comp;
      end
      assign pix_tri[PIX_W-1-i*COMP_W -: COMP_W] = part_q[i];
    end
  endgenerate
  assign pix_tri[COMP_W-1:0] = comp;

  assign load      = in_fire && (!tri_q || last_ph);
  assign load_data = tri_q ? pix_tri : in_data;

  pxa_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .take(out_ready), .valid(out_valid), .pixel(out_pixel)
  );

  // R2
  partial_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && tri_q && !last_ph) |=> !out_valid);

  // R2
  closing_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && tri_q && last_ph) |=> out_valid);

  // R6
  single_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !tri_q) |=> (out_valid && out_pixel == $past(in_data)));
endmodule

// File: tb/pix_assembler_bench.sv
module pix_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, mode_tri = 1'b0;
  logic [1:0]  mode_fmt = 2'b10;
  logic        in_valid = 1'b0, in_ready;
  logic [17:0] in_data = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [17:0] out_pixel;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pix_assembler u_pix_assembler (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_tri(mode_tri),
    .mode_fmt(mode_fmt), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel)
  );

  // {fmt[1:0], byte0, byte1, byte2, expected pixel[17:0]}
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {2'b10, 8'hFC, 8'h00, 8'h54, 18'h3F015},  // R3
    {2'b10, 8'h03, 8'h03, 8'h03, 18'h00000},  // R3 low bits ignored
    {2'b11, 8'hF8, 8'hFC, 8'hF8, 18'h3FFFF},  // R4
    {2'b11, 8'h80, 8'h00, 8'h08, 18'h21002},  // R4 widening
    {2'b11, 8'h78, 8'hA4, 8'h10, 18'h1EA44},  // R4
    {2'b11, 8'h07, 8'h03, 8'h07, 18'h00000},  // R4 low bits ignored
    {2'b00, 8'h04, 8'h08, 8'h0C, 18'h01083},  // R5
    {2'b01, 8'hFF, 8'hFF, 8'hFF, 18'h3FFFF}   // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mode_write(input logic t, input logic [1:0] f);
    @(negedge clk);
    mode_wr = 1'b1; mode_tri = t; mode_fmt = f;
    #1 chk(in_ready == 1'b0, "R7 ready low on mode write", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic put(input logic [17:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pixel3(input logic [7:0] b0, b1, b2, input logic [17:0] exp,
                        input string req);
    put({10'd0, b0});
    chk(!out_valid, "R2 no output after byte 1", {31'd0, out_valid}, 32'd0);
    put({10'd0, b1});
    chk(!out_valid, "R2 no output after byte 2", {31'd0, out_valid}, 32'd0);
    put({10'd0, b2});
    chk(out_valid && out_pixel == exp, req, {14'd0, out_pixel}, {14'd0, exp});
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && in_ready, "R1 reset state", {30'd0, out_valid, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      mode_write(1'b1, VEC[i][43:42]);
      pixel3(VEC[i][41:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:0],
             "R3/R4/R5 pixel value");
    end

    // R1: the first byte after reset counts as component one (reset again)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    mode_write(1'b1, 2'b10);
    pixel3(8'h04, 8'h08, 8'h0C, 18'h01083, "R1 phase starts at 0");

    // R6 single-transfer mode
    mode_write(1'b0, 2'b10);
    put(18'h2ABCD);
    chk(out_valid && out_pixel == 18'h2ABCD, "R6 pass-through", {14'd0, out_pixel}, 32'h2ABCD);
    put(18'h15432);
    chk(out_valid && out_pixel == 18'h15432, "R6 pass-through 2", {14'd0, out_pixel}, 32'h15432);

    // R7 mode write discards a partial pixel
    mode_write(1'b1, 2'b10);
    put(18'h000FC);
    put(18'h000FC);
    mode_write(1'b1, 2'b11);
    pixel3(8'h80, 8'h00, 8'h08, 18'h21002, "R7 partial discarded");

    // R8 back-pressure
    @(negedge clk); out_ready = 1'b0;
    pixel3(8'hF8, 8'hFC, 8'hF8, 18'h3FFFF, "R8 pixel before stall");
    repeat (3) @(negedge clk);
    chk(out_valid && out_pixel == 18'h3FFFF, "R8 held while stalled",
        {14'd0, out_pixel}, 32'h3FFFF);
    chk(!in_ready, "R8 ready low while stalled", {31'd0, in_ready}, 32'd0);
    put(18'h000FC);  // refused: in_ready is low
    chk(out_valid && out_pixel == 18'h3FFFF, "R8 refused byte no effect",
        {14'd0, out_pixel}, 32'h3FFFF);
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R8 released", {31'd0, out_valid}, 32'd0);
    pixel3(8'h78, 8'hA4, 8'h10, 18'h1EA44, "R8 refused byte not counted");

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule